// File: doc/BRIEF.md
# Host-to-DSP Memory Write Mailbox

This block lets a host processor place 16-bit words into a DSP's data memory through a small byte-wide register file. It has several independent channels (two by default). Each channel holds a target address, a memory-space choice and a data word. The host arms a channel by setting its start bit together with its write-enable bit.

Writes leave the block only on a service tick. The tick is a one-cycle strobe that marks the DSP's baud or sample instant. Each armed channel is served at most once per tick. The lowest-numbered channel goes out in the tick cycle itself, and the rest follow in the cycles after it, one per cycle.

A finished transfer clears the start bit and sets a done flag. Two interrupt paths then report it:
- The first is an acknowledged, sticky interrupt. The host clears it by writing the data-low register.
- The second is a level interrupt. It follows the done flag, which clears when the host reads the data-low register.

Top module: `mbox_top`

## Requirements
- R1: After reset every register reads 0, `dsp_we_o` is 0 and both `irq1_no` and `irq2_no` are 1. Host registers for channel c sit at host address c*8+k. A read returns its data on `host_rdata_o` in the cycle after `host_re_i`.
- R2: Register offsets k are: 0 address byte, 1 control, 2 data low, 3 data high, 4 bank address low, 5 bank address high, 6 status. The control byte reads back as written, with bit0 reflecting the live start bit.
- R3: Main mode applies when control bit5 is 0. The DSP address is {control[3:2], address byte}. `dsp_space_o` is 0 when control bit4 is 0 (X space) and 1 when it is 1 (Y space). `dsp_data_o` is {data high, data low}.
- R4: Single-bank mode applies when control bit5 is 1. The DSP address is the low AW bits of {bank high, bank low}, and `dsp_space_o` is 2.
- R5: A write happens only as a result of a tick. An armed channel is written once per tick, and no second write to it occurs until a later tick. Completion clears the start bit (status bit2) and sets the done flag (status bit0) one cycle after the write.
- R6: When several channels are armed at a tick, channel 0 is written in the tick cycle and channel 1 in the following cycle.
- R7: A control write with bit0=1 and bit1 (write select) 0 leaves the start bit at 0. No DSP write and no done flag follow.
- R8: A host read of the data-low register clears that channel's done flag.
- R9: When a transfer completes with control bit6 set, the channel's interrupt-active bit (status bit1) sets. `irq1_no` is 0 while any channel's interrupt-active bit is 1. A host write to data low clears that channel's bit.
- R10: `irq2_no` is 0 while any channel has both its done flag and control bit7 set. Bit7 never sets the interrupt-active bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_addr_i | input | HAW | Host register address (channel, offset) |
| host_wdata_i | input | 8 | Host write data |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe |
| host_rdata_o | output | 8 | Host read data, one cycle after read strobe |
| tick_i | input | 1 | Service tick strobe |
| dsp_we_o | output | 1 | DSP memory write strobe |
| dsp_addr_o | output | AW | DSP memory address |
| dsp_data_o | output | 16 | DSP memory write data |
| dsp_space_o | output | 2 | Space select: 0 X, 1 Y, 2 single bank |
| irq1_no | output | 1 | Acknowledged interrupt, active low |
| irq2_no | output | 1 | Level interrupt, active low, follows done |

## Verification
The bench uses the default build: two channels and a 10-bit DSP address. With these values every extension field and both space selects can be swept on each channel. Bank addresses wider than the port show the truncation. Two channels are enough to show the tick-cycle ordering and the shared interrupt line, which stays asserted until the last channel is acknowledged.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned DW    = 16;
  localparam int unsigned EXT_W = 2;

  typedef enum logic [2:0] {
    RG_ADDR = 3'd0,
    RG_CTRL = 3'd1,
    RG_DLO  = 3'd2,
    RG_DHI  = 3'd3,
    RG_SBL  = 3'd4,
    RG_SBH  = 3'd5,
    RG_STAT = 3'd6
  } reg_e;

  typedef enum logic [1:0] {
    SP_X  = 2'd0,
    SP_Y  = 2'd1,
    SP_SB = 2'd2
  } space_e;

  typedef struct packed {
    logic [DW-1:0] data;
    space_e        space;
  } xfer_t;
endpackage

// File: rtl/mbox_arb.sv
module mbox_arb #(
  parameter int unsigned N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [N_CH-1:0] pend_i,
  output logic [N_CH-1:0] grant_o
);
  logic [N_CH-1:0] armed_q, eff;
  logic            found;

  always_comb begin
    eff     = armed_q | (tick_i ? pend_i : '0);
    grant_o = '0;
    found   = 1'b0;
    for (int i = 0; i < int'(N_CH); i++) begin
      if (eff[i] && pend_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  // channels still owed a write for the current tick
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed_q <= '0;
    else         armed_q <= eff & pend_i & ~grant_o;

  for (genvar g = 0; g < int'(N_CH); g++) begin : g_chk
    assert_once_per_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[g] |=> (!grant_o[g] || tick_i));
    assert_grant_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[g] |-> pend_i[g]);
  end

  assert_burst_follows_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o && !tick_i) |-> $past(|grant_o));
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
  import mbox_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [2:0]    reg_i,
  input  logic [7:0]    wdata_i,
  input  logic          served_i,
  output logic          pend_o,
  output logic [AW-1:0] addr_o,
  output xfer_t         req_o,
  output logic [7:0]    rdata_o,
  output logic          ia_o,
  output logic          lvl_o
);
  logic [7:0]       abyte_q, dlo_q, dhi_q, sbl_q, sbh_q;
  logic             acc_q, wsel_q, ysp_q, sb_q, ie1_q, ie2_q;
  logic [EXT_W-1:0] ext_q;
  logic             done_q, ia_q;
  logic             wr_ctrl, wr_lo, rd_lo;

  assign wr_ctrl = wr_i && (reg_i == RG_CTRL);
  assign wr_lo   = wr_i && (reg_i == RG_DLO);
  assign rd_lo   = rd_i && (reg_i == RG_DLO);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      abyte_q <= '0; dlo_q <= '0; dhi_q <= '0; sbl_q <= '0; sbh_q <= '0;
      wsel_q <= 1'b0; ysp_q <= 1'b0; sb_q <= 1'b0; ie1_q <= 1'b0; ie2_q <= 1'b0;
      ext_q <= '0;
    end else if (wr_i) begin
      case (reg_i)
        RG_ADDR: abyte_q <= wdata_i;
        RG_CTRL: begin
          wsel_q <= wdata_i[1];
          ext_q  <= wdata_i[3:2];
          ysp_q  <= wdata_i[4];
          sb_q   <= wdata_i[5];
          ie1_q  <= wdata_i[6];
          ie2_q  <= wdata_i[7];
        end
        RG_DLO:  dlo_q <= wdata_i;
        RG_DHI:  dhi_q <= wdata_i;
        RG_SBL:  sbl_q <= wdata_i;
        RG_SBH:  sbh_q <= wdata_i;
        default: ;
      endcase
    end

  // start bit only arms with write select; a host write beats auto-clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       acc_q <= 1'b0;
    else if (wr_ctrl)  acc_q <= wdata_i[0] & wdata_i[1];
    else if (served_i) acc_q <= 1'b0;

  // completion wins over same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      done_q <= 1'b0;
      ia_q   <= 1'b0;
    end else begin
      if (served_i)   done_q <= 1'b1;
      else if (rd_lo) done_q <= 1'b0;
      if (served_i && ie1_q) ia_q <= 1'b1;
      else if (wr_lo)        ia_q <= 1'b0;
    end

  assign pend_o     = acc_q;
  assign addr_o     = sb_q ? AW'({sbh_q, sbl_q}) : AW'({ext_q, abyte_q});
  assign req_o.data = {dhi_q, dlo_q};
  assign req_o.space = sb_q ? SP_SB : (ysp_q ? SP_Y : SP_X);
  assign ia_o       = ia_q;
  assign lvl_o      = done_q & ie2_q;

  always_comb begin
    case (reg_i)
      RG_ADDR: rdata_o = abyte_q;
      RG_CTRL: rdata_o = {ie2_q, ie1_q, sb_q, ysp_q, ext_q, wsel_q, acc_q};
      RG_DLO:  rdata_o = dlo_q;
      RG_DHI:  rdata_o = dhi_q;
      RG_SBL:  rdata_o = sbl_q;
      RG_SBH:  rdata_o = sbh_q;
      RG_STAT: rdata_o = {5'd0, acc_q, ia_q, done_q};
      default: rdata_o = 8'd0;
    endcase
  end

  assert_done_after_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    served_i |=> done_q);
  assert_start_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (served_i && !wr_ctrl) |=> !acc_q);
  assert_start_needs_wsel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |-> wsel_q);
  assert_read_clears_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo && !served_i) |=> !done_q);
  assert_ia_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ia_q) |-> done_q);
endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int unsigned N_CH = 2,
  parameter int unsigned AW   = 10,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned HAW  = CH_W + 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [HAW-1:0] host_addr_i,
  input  logic [7:0]     host_wdata_i,
  input  logic           host_we_i,
  input  logic           host_re_i,
  output logic [7:0]     host_rdata_o,
  input  logic           tick_i,
  output logic           dsp_we_o,
  output logic [AW-1:0]  dsp_addr_o,
  output logic [DW-1:0]  dsp_data_o,
  output logic [1:0]     dsp_space_o,
  output logic           irq1_no,
  output logic           irq2_no
);
  logic [CH_W-1:0] ch_sel;
  logic [2:0]      reg_sel;
  logic [N_CH-1:0] pend, grant, ia, lvl, hit;
  logic [AW-1:0]   ch_addr [N_CH];
  xfer_t           ch_req  [N_CH];
  logic [7:0]      ch_rd   [N_CH];
  logic [7:0]      rd_mux, rdata_q;

  assign ch_sel  = host_addr_i[HAW-1:3];
  assign reg_sel = host_addr_i[2:0];

  for (genvar c = 0; c < int'(N_CH); c++) begin : g_ch
    assign hit[c] = (ch_sel == CH_W'(c));
    mbox_chan #(.AW(AW)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (host_we_i && hit[c]),
      .rd_i     (host_re_i && hit[c]),
      .reg_i    (reg_sel),
      .wdata_i  (host_wdata_i),
      .served_i (grant[c]),
      .pend_o   (pend[c]),
      .addr_o   (ch_addr[c]),
      .req_o    (ch_req[c]),
      .rdata_o  (ch_rd[c]),
      .ia_o     (ia[c]),
      .lvl_o    (lvl[c])
    );
  end

  mbox_arb #(.N_CH(N_CH)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .pend_i  (pend),
    .grant_o (grant)
  );

  always_comb begin
    dsp_addr_o  = '0;
    dsp_data_o  = '0;
    dsp_space_o = '0;
    rd_mux      = '0;
    for (int i = 0; i < int'(N_CH); i++) begin
      if (grant[i]) begin
        dsp_addr_o  |= ch_addr[i];
        dsp_data_o  |= ch_req[i].data;
        dsp_space_o |= ch_req[i].space;
      end
      if (hit[i]) rd_mux |= ch_rd[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        rdata_q <= '0;
    else if (host_re_i) rdata_q <= rd_mux;

  assign dsp_we_o     = |grant;
  assign host_rdata_o = rdata_q;
  assign irq1_no      = ~|ia;
  assign irq2_no      = ~|lvl;

  assert_space_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsp_we_o |-> (dsp_space_o != 2'd3));
  assert_no_write_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !$past(dsp_we_o)) |-> !dsp_we_o);
endmodule

// File: tb/mbox_top_tb.sv
`timescale 1ns/1ps
module mbox_top_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] haddr = '0;
  logic [7:0] hwd = '0;
  logic       hwe = 1'b0, hre = 1'b0, tick = 1'b0;
  logic [7:0] hrd;
  logic       we, irq1_n, irq2_n;
  logic [9:0] daddr;
  logic [15:0] ddata;
  logic [1:0] dsp;
  int checks = 0, errors = 0;

  logic       cw [2];
  logic [9:0] ca [2];
  logic [15:0] cd [2];
  logic [1:0] cs [2];

  always #2.5 clk = ~clk;

  mbox_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(haddr), .host_wdata_i(hwd),
    .host_we_i(hwe), .host_re_i(hre), .host_rdata_o(hrd), .tick_i(tick),
    .dsp_we_o(we), .dsp_addr_o(daddr), .dsp_data_o(ddata), .dsp_space_o(dsp),
    .irq1_no(irq1_n), .irq2_no(irq2_n)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int k, int d);
    @(negedge clk);
    haddr = 4'(ch * 8 + k); hwd = 8'(d); hwe = 1'b1;
    @(negedge clk);
    hwe = 1'b0;
  endtask

  task automatic rd(int ch, int k, output int v);
    @(negedge clk);
    haddr = 4'(ch * 8 + k); hre = 1'b1;
    @(negedge clk);
    hre = 1'b0;
    v = int'(hrd);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1; #1;
    cw[0] = we; ca[0] = daddr; cd[0] = ddata; cs[0] = dsp;
    @(negedge clk);
    tick = 1'b0; #1;
    cw[1] = we; ca[1] = daddr; cd[1] = ddata; cs[1] = dsp;
    @(negedge clk);
  endtask

  function automatic int ctrl_byte(int ie2, int ie1, int sb, int y, int ext, int ws, int go);
    return (ie2 << 7) | (ie1 << 6) | (sb << 5) | (y << 4) | ((ext & 3) << 2) | (ws << 1) | go;
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, ab, ext, sbw, dat, sb, y, exp_a, exp_s;
    #12 rst_n = 1'b1;
    @(negedge clk);
    check("R1 dsp_we", int'(we), 0);
    check("R1 irq1", int'(irq1_n), 1);
    check("R1 irq2", int'(irq2_n), 1);
    for (int ch = 0; ch < 2; ch++)
      for (int k = 0; k < 7; k++) begin
        rd(ch, k, v);
        check("R1 reset reg", v, 0);
      end

    // R2: control readback without start
    wr(1, 1, 'hC4);
    rd(1, 1, v);
    check("R2 ctrl readback", v, 'hC4);
    wr(1, 1, 0);

    // sweep both channels over modes, spaces, extensions and data
    for (int ch = 0; ch < 2; ch++)
      for (int k = 0; k < 16; k++) begin
        sb  = k & 1;
        y   = (k >> 1) & 1;
        ext = (k >> 2) & 3;
        ab  = (k * 37 + ch * 11 + 5) & 'hFF;
        sbw = (k * 1237 + ch * 313 + 7) & 'hFFFF;
        dat = (k * 4099 + ch * 771 + 1) & 'hFFFF;
        wr(ch, 0, ab);
        wr(ch, 4, sbw & 'hFF);
        wr(ch, 5, sbw >> 8);
        wr(ch, 2, dat & 'hFF);
        wr(ch, 3, dat >> 8);
        wr(ch, 1, ctrl_byte(0, 0, sb, y, ext, 1, 1));
        @(negedge clk); #1;
        check("R5 no write before tick", int'(we), 0);
        rd(ch, 6, v);
        check("R5 start pending", v, 4);
        pulse_tick();
        exp_a = sb ? (sbw & 'h3FF) : ((ext << 8) | ab);
        exp_s = sb ? 2 : y;
        check(sb ? "R4 write strobe" : "R3 write strobe", int'(cw[0]), 1);
        check(sb ? "R4 address" : "R3 address", int'(ca[0]), exp_a);
        check(sb ? "R4 space" : "R3 space", int'(cs[0]), exp_s);
        check("R3 data", int'(cd[0]), dat);
        check("R5 single write per tick", int'(cw[1]), 0);
        rd(ch, 6, v);
        check("R5 done set start cleared", v, 1);
        rd(ch, 2, v);
        check("R8 data low readback", v, dat & 'hFF);
        rd(ch, 6, v);
        check("R8 done cleared by read", v, 0);
      end

    // R7: start without write select
    wr(0, 1, ctrl_byte(0, 0, 0, 0, 0, 0, 1));
    rd(0, 6, v);
    check("R7 start not retained", v, 0);
    pulse_tick();
    check("R7 no write", int'(cw[0]) + int'(cw[1]), 0);
    rd(0, 6, v);
    check("R7 no done", v, 0);

    // R6: both armed in one tick
    wr(0, 0, 'h11); wr(0, 2, 'h22); wr(0, 3, 'h33);
    wr(1, 0, 'h44); wr(1, 2, 'h55); wr(1, 3, 'h66);
    wr(0, 1, ctrl_byte(0, 0, 0, 0, 1, 1, 1));
    wr(1, 1, ctrl_byte(0, 0, 0, 1, 2, 1, 1));
    pulse_tick();
    check("R6 ch0 in tick cycle", int'(ca[0]), 'h111);
    check("R6 ch0 data", int'(cd[0]), 'h3322);
    check("R6 ch1 next cycle", int'(cw[1]), 1);
    check("R6 ch1 address", int'(ca[1]), 'h244);
    check("R6 ch1 space", int'(cs[1]), 1);
    pulse_tick();
    check("R5 no repeat on later tick", int'(cw[0]) + int'(cw[1]), 0);
    rd(0, 2, v); rd(1, 2, v);

    // R9: sticky interrupt on both channels
    wr(0, 1, ctrl_byte(0, 1, 0, 0, 0, 1, 1));
    wr(1, 1, ctrl_byte(0, 1, 0, 0, 0, 1, 1));
    pulse_tick();
    check("R9 irq1 asserted", int'(irq1_n), 0);
    check("R10 irq2 idle without enable", int'(irq2_n), 1);
    wr(0, 2, 'h5A);
    check("R9 irq1 held by other channel", int'(irq1_n), 0);
    rd(0, 6, v);
    check("R9 ia cleared done kept", v, 1);
    wr(1, 2, 'hA5);
    check("R9 irq1 released", int'(irq1_n), 1);
    rd(0, 2, v); rd(1, 2, v);

    // R10: level interrupt
    wr(0, 1, ctrl_byte(1, 0, 0, 0, 0, 1, 1));
    pulse_tick();
    check("R10 irq2 asserted", int'(irq2_n), 0);
    check("R10 irq1 unaffected", int'(irq1_n), 1);
    rd(0, 6, v);
    check("R10 ia not set", v, 1);
    wr(0, 2, 'h00);
    check("R10 irq2 held after data write", int'(irq2_n), 0);
    rd(0, 2, v);
    check("R10 irq2 released on read", int'(irq2_n), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule